// File: doc/BRIEF.md
# Stack Register Save/Restore Sequencer

This block expands one decoded save-multiple or restore-multiple operation into a series of single-word stack accesses. It latches the decoded fields when `start` is seen while idle: a 6-bit upper and lower register bound, three option flags (link register, global pointer, stack guard word), a direction bit and a return-mode bit. It then walks the selected registers through a one-outstanding-request memory port. On a save it reads the register file and pre-decrements the stack pointer for each word. On a restore it post-increments the stack pointer and writes the register file.

A save can append a guard word that is computed from the stack pointer, so that each frame gets a different value. A restore recomputes that value and compares it with the word read back. A mismatch is flagged and cancels any return jump. The stack pointer is written back once, in the completion cycle. If the operation asks for it, the program counter is loaded from the restored link value in that same cycle.

Top module: `stm_ldm_seq`

## Requirements
- R1: A save (`isLoad`=0) issues its writes in this order: the link register (index 1) if `saveLink`, then the global pointer (index 3) if `saveGp`, then registers `loBound` up to `hiBound`, then the guard word if `useCanary`. Each write goes to the stack pointer already decremented by 8, starting from `spIn`.
- R2: The register range is transferred only when `hiBound` >= `loBound`. Equal bounds move exactly one register, and an operation with no words finishes without any memory request.
- R3: The guard word equals 64'h5A3C_96E1_0F2D_B487 XOR the address of the slot that it occupies.
- R4: A restore (`isLoad`=1) reads in the reverse order: guard word, then registers `hiBound` down to `loBound`, then the global pointer, then the link register. Addresses start at `spIn` and rise by 8. Each read value is written into its register.
- R5: `spWrEn` is high only in the completion cycle. `spWrData` then equals `spIn` minus 8 times the word count on a save, or plus 8 times the word count on a restore.
- R6: On a restore with `saveLink` and `linkToPc` set, the link word is not written to register 1. Instead `pcWrEn` rises with `done` and `pcWrData` equals that word. With `linkToPc` clear, the word goes into register 1 and `pcWrEn` stays low.
- R7: If the guard word read on a restore differs from the recomputed value, `canaryFault` is high in the completion cycle and `pcWrEn` stays low.
- R8: At most one request is outstanding. `memReq` stays high with a stable address and write data until `memAck` is seen.
- R9: `busy` is high from the cycle after an accepted `start` until the last access is acknowledged. `done` is a one-cycle pulse, and a `start` seen while busy is ignored.
- R10: After reset the block is idle: `busy`, `done`, `memReq`, `spWrEn` and `pcWrEn` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (accepted when idle) |
| isLoad | input | 1 | 1 = restore, 0 = save |
| hiBound | input | 6 | Upper register bound |
| loBound | input | 6 | Lower register bound |
| saveLink | input | 1 | Include link register |
| saveGp | input | 1 | Include global pointer |
| useCanary | input | 1 | Include guard word |
| linkToPc | input | 1 | Restore link word into PC instead of register |
| spIn | input | 64 | Stack pointer at start |
| busy | output | 1 | Accesses pending |
| done | output | 1 | Completion pulse |
| canaryFault | output | 1 | Guard word mismatch, valid with done |
| rfRdAddr | output | 6 | Register file read index |
| rfRdData | input | 64 | Register file read data |
| rfWrEn | output | 1 | Register file write enable |
| rfWrAddr | output | 6 | Register file write index |
| rfWrData | output | 64 | Register file write data |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Memory write |
| memAddr | output | 64 | Memory address |
| memWdata | output | 64 | Memory write data |
| memAck | input | 1 | Memory response |
| memRdata | input | 64 | Memory read data |
| spWrEn | output | 1 | Stack pointer write enable |
| spWrData | output | 64 | Final stack pointer |
| pcWrEn | output | 1 | Program counter redirect |
| pcWrData | output | 64 | Redirect target |

## Verification
The hardest case to reach from the ports is a guard mismatch on a restore. A block that saves correctly never produces a bad guard word. The stimulus therefore saves a frame, flips one bit of the guard slot in the bench memory model, and restores with the return option set, which must yield a fault and no redirect. A second start pulse is also raised during a long 64-register save with acknowledge delays. The scoreboard then shows that the running sequence is not disturbed.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LINK, ST_GP, ST_RANGE, ST_CANARY, ST_FINISH
  } step_t;

  typedef struct packed {
    logic init;
    logic advance;
    logic isLoad;
    logic canaryStep;
    logic capPc;
    logic finish;
  } seqStrobe_t;
endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int RW       = 6,
  parameter int LINK_IDX = 1,
  parameter int GP_IDX   = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          isLoad,
  input  logic [RW-1:0] hiBound,
  input  logic [RW-1:0] loBound,
  input  logic          saveLink,
  input  logic          saveGp,
  input  logic          useCanary,
  input  logic          linkToPc,
  input  logic          memAck,
  output logic [RW-1:0] regIdx,
  output logic          memReq,
  output logic          memWe,
  output logic          rfWrEn,
  output logic          busy,
  output logic          done,
  output seqStrobe_t    strobe
);
  step_t step;
  logic opLoad, opLink, opGp, opCan, opToPc;
  logic [RW-1:0] opHi, opLo, idx;
  logic [RW-1:0] rangeEnd;

  function automatic step_t nextStep(input step_t from, input logic ld, input logic lk,
                                     input logic gp, input logic rng, input logic cn);
    step_t r;
    r = ST_FINISH;
    if (!ld) begin
      if (from == ST_IDLE && lk) r = ST_LINK;
      else if ((from == ST_IDLE || from == ST_LINK) && gp) r = ST_GP;
      else if ((from == ST_IDLE || from == ST_LINK || from == ST_GP) && rng) r = ST_RANGE;
      else if (from != ST_CANARY && cn) r = ST_CANARY;
    end else begin
      if (from == ST_IDLE && cn) r = ST_CANARY;
      else if ((from == ST_IDLE || from == ST_CANARY) && rng) r = ST_RANGE;
      else if ((from == ST_IDLE || from == ST_CANARY || from == ST_RANGE) && gp) r = ST_GP;
      else if (from != ST_LINK && lk) r = ST_LINK;
    end
    return r;
  endfunction

  assign rangeEnd = opLoad ? opLo : opHi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      step   <= ST_IDLE;
      opLoad <= 1'b0;
      opLink <= 1'b0;
      opGp   <= 1'b0;
      opCan  <= 1'b0;
      opToPc <= 1'b0;
      opHi   <= '0;
      opLo   <= '0;
      idx    <= '0;
    end else begin
      case (step)
        ST_IDLE: begin
          if (start) begin
            opLoad <= isLoad;
            opLink <= saveLink;
            opGp   <= saveGp;
            opCan  <= useCanary;
            opToPc <= linkToPc;
            opHi   <= hiBound;
            opLo   <= loBound;
            idx    <= isLoad ? hiBound : loBound;
            step   <= nextStep(ST_IDLE, isLoad, saveLink, saveGp,
                               hiBound >= loBound, useCanary);
          end
        end
        ST_FINISH: step <= ST_IDLE;
        default: begin
          if (memAck) begin
            if (step == ST_RANGE && idx != rangeEnd)
              idx <= opLoad ? idx - 1'b1 : idx + 1'b1;
            else
              step <= nextStep(step, opLoad, opLink, opGp, opHi >= opLo, opCan);
          end
        end
      endcase
    end
  end

  always_comb begin
    case (step)
      ST_LINK:  regIdx = RW'(LINK_IDX);
      ST_GP:    regIdx = RW'(GP_IDX);
      ST_RANGE: regIdx = idx;
      default:  regIdx = '0;
    endcase
  end

  assign memReq = (step == ST_LINK) || (step == ST_GP) || (step == ST_RANGE) || (step == ST_CANARY);
  assign memWe  = memReq && !opLoad;
  assign busy   = memReq;
  assign done   = (step == ST_FINISH);
  assign rfWrEn = memReq && memAck && opLoad &&
                  ((step == ST_GP) || (step == ST_RANGE) || (step == ST_LINK && !opToPc));

  assign strobe.init       = start && (step == ST_IDLE);
  assign strobe.advance    = memReq && memAck;
  assign strobe.isLoad     = opLoad;
  assign strobe.canaryStep = (step == ST_CANARY);
  assign strobe.capPc      = memReq && memAck && opLoad && opToPc && (step == ST_LINK);
  assign strobe.finish     = (step == ST_FINISH);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_hold_req_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(regIdx)));
  assert_no_req_at_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memReq);
  assert_pc_not_written_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rfWrEn && opToPc) |-> (regIdx != RW'(LINK_IDX) || step != ST_LINK));
endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int          XLEN  = 64,
  parameter logic [63:0] MAGIC = 64'h5A3C_96E1_0F2D_B487
) (
  input  logic            clk,
  input  logic            rstN,
  input  seqStrobe_t      strobe,
  input  logic [XLEN-1:0] spIn,
  input  logic [XLEN-1:0] rfRdData,
  input  logic [XLEN-1:0] memRdata,
  output logic [XLEN-1:0] memAddr,
  output logic [XLEN-1:0] memWdata,
  output logic            spWrEn,
  output logic [XLEN-1:0] spWrData,
  output logic            pcWrEn,
  output logic [XLEN-1:0] pcWrData,
  output logic            canaryFault
);
  localparam logic [XLEN-1:0] WORD_BYTES = XLEN'(XLEN / 8);
  localparam logic [XLEN-1:0] GUARD_KEY  = MAGIC[XLEN-1:0];

  logic [XLEN-1:0] spCur, slotAddr, guardVal, pcTarget;
  logic faultFlag, pcPending;

  assign slotAddr = strobe.isLoad ? spCur : spCur - WORD_BYTES;
  assign guardVal = GUARD_KEY ^ slotAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spCur     <= '0;
      faultFlag <= 1'b0;
      pcPending <= 1'b0;
      pcTarget  <= '0;
    end else if (strobe.init) begin
      spCur     <= spIn;
      faultFlag <= 1'b0;
      pcPending <= 1'b0;
    end else if (strobe.advance) begin
      spCur <= strobe.isLoad ? spCur + WORD_BYTES : spCur - WORD_BYTES;
      if (strobe.isLoad && strobe.canaryStep && memRdata != guardVal)
        faultFlag <= 1'b1;
      if (strobe.capPc) begin
        pcPending <= 1'b1;
        pcTarget  <= memRdata;
      end
    end
  end

  assign memAddr     = slotAddr;
  assign memWdata    = strobe.canaryStep ? guardVal : rfRdData;
  assign spWrEn      = strobe.finish;
  assign spWrData    = spCur;
  assign canaryFault = strobe.finish && faultFlag;
  assign pcWrEn      = strobe.finish && pcPending && !faultFlag;
  assign pcWrData    = pcTarget;

  assert_fault_blocks_pc_R7: assert property (@(posedge clk) disable iff (!rstN)
    pcWrEn |-> (!canaryFault && spWrEn));
  assert_fault_only_at_end_R7: assert property (@(posedge clk) disable iff (!rstN)
    canaryFault |-> spWrEn);
endmodule

// File: rtl/stm_ldm_seq.sv
module stm_ldm_seq
  import seq_pkg::*;
#(
  parameter int          XLEN     = 64,
  parameter int          NREG     = 64,
  parameter int          LINK_IDX = 1,
  parameter int          GP_IDX   = 3,
  parameter logic [63:0] MAGIC    = 64'h5A3C_96E1_0F2D_B487,
  localparam int         RW       = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic            isLoad,
  input  logic [RW-1:0]   hiBound,
  input  logic [RW-1:0]   loBound,
  input  logic            saveLink,
  input  logic            saveGp,
  input  logic            useCanary,
  input  logic            linkToPc,
  input  logic [XLEN-1:0] spIn,
  output logic            busy,
  output logic            done,
  output logic            canaryFault,
  output logic [RW-1:0]   rfRdAddr,
  input  logic [XLEN-1:0] rfRdData,
  output logic            rfWrEn,
  output logic [RW-1:0]   rfWrAddr,
  output logic [XLEN-1:0] rfWrData,
  output logic            memReq,
  output logic            memWe,
  output logic [XLEN-1:0] memAddr,
  output logic [XLEN-1:0] memWdata,
  input  logic            memAck,
  input  logic [XLEN-1:0] memRdata,
  output logic            spWrEn,
  output logic [XLEN-1:0] spWrData,
  output logic            pcWrEn,
  output logic [XLEN-1:0] pcWrData
);
  seqStrobe_t strobe;
  logic [RW-1:0] regIdx;

  seq_ctrl #(.RW(RW), .LINK_IDX(LINK_IDX), .GP_IDX(GP_IDX)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .isLoad(isLoad),
    .hiBound(hiBound), .loBound(loBound), .saveLink(saveLink), .saveGp(saveGp),
    .useCanary(useCanary), .linkToPc(linkToPc), .memAck(memAck),
    .regIdx(regIdx), .memReq(memReq), .memWe(memWe), .rfWrEn(rfWrEn),
    .busy(busy), .done(done), .strobe(strobe)
  );

  seq_datapath #(.XLEN(XLEN), .MAGIC(MAGIC)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .spIn(spIn),
    .rfRdData(rfRdData), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata),
    .spWrEn(spWrEn), .spWrData(spWrData),
    .pcWrEn(pcWrEn), .pcWrData(pcWrData), .canaryFault(canaryFault)
  );

  assign rfRdAddr = regIdx;
  assign rfWrAddr = regIdx;
  assign rfWrData = memRdata;

  assert_stable_addr_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> $stable(memAddr) && $stable(memWe));
  assert_stable_wdata_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && !memAck) |=> $stable(memWdata));
  assert_sp_once_R5: assert property (@(posedge clk) disable iff (!rstN)
    spWrEn |-> (done && !busy));
  assert_idle_no_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !rfWrEn);
endmodule

// File: tb/stm_ldm_seq_tb.sv
module stm_ldm_seq_tb;
  localparam logic [63:0] MAGIC = 64'h5A3C_96E1_0F2D_B487;

  logic clk = 0, rstN = 0;
  logic start = 0, isLoad = 0, saveLink = 0, saveGp = 0, useCanary = 0, linkToPc = 0;
  logic [5:0] hiBound = 0, loBound = 0;
  logic [63:0] spIn = 0;
  logic busy, done, canaryFault, rfWrEn, memReq, memWe, spWrEn, pcWrEn;
  logic [5:0] rfRdAddr, rfWrAddr;
  logic [63:0] rfRdData, rfWrData, memAddr, memWdata, spWrData, pcWrData;
  logic memAck = 0;
  logic [63:0] memRdata = 0;

  logic [63:0] regs [64];
  logic [63:0] mem [logic [63:0]];
  int total = 0, bad = 0, ackDelay = 0, waitCnt = 0;

  typedef struct packed { logic we; logic [63:0] addr; logic [63:0] data; } acc_t;
  acc_t expQ[$];
  string tagQ[$];

  always #2 clk = ~clk;

  stm_ldm_seq u_dut (
    .clk(clk), .rstN(rstN), .start(start), .isLoad(isLoad), .hiBound(hiBound),
    .loBound(loBound), .saveLink(saveLink), .saveGp(saveGp), .useCanary(useCanary),
    .linkToPc(linkToPc), .spIn(spIn), .busy(busy), .done(done), .canaryFault(canaryFault),
    .rfRdAddr(rfRdAddr), .rfRdData(rfRdData), .rfWrEn(rfWrEn), .rfWrAddr(rfWrAddr),
    .rfWrData(rfWrData), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata), .spWrEn(spWrEn),
    .spWrData(spWrData), .pcWrEn(pcWrEn), .pcWrData(pcWrData)
  );

  assign rfRdData = regs[rfRdAddr];
  always @(posedge clk) if (rfWrEn) regs[rfWrAddr] <= rfWrData;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // memory responder and scoreboard monitor
  always @(negedge clk) begin
    if (memAck) memAck = 0;
    else if (memReq) begin
      if (waitCnt < ackDelay) waitCnt++;
      else begin
        acc_t e;
        string t;
        waitCnt = 0;
        if (expQ.size() == 0) chk(0, "R8", "unexpected request", memAddr, 0);
        else begin
          e = expQ.pop_front();
          t = tagQ.pop_front();
          chk(memWe == e.we && memAddr == e.addr, t, "access kind/address",
              {memWe, memAddr[62:0]}, {e.we, e.addr[62:0]});
          if (e.we) chk(memWdata == e.data, t, "write data", memWdata, e.data);
        end
        if (memWe) mem[memAddr] = memWdata;
        else memRdata = mem.exists(memAddr) ? mem[memAddr] : 64'h0;
        memAck = 1;
      end
    end
  end

  task automatic push(input logic we, input logic [63:0] a, input logic [63:0] d, input string t);
    expQ.push_back('{we, a, d});
    tagQ.push_back(t);
  endtask

  task automatic runOp(input bit ld, input logic [5:0] hi, input logic [5:0] lo,
                       input bit lk, input bit gp, input bit cn, input bit toPc,
                       input logic [63:0] sp, input bit expFault, input logic [63:0] expPc,
                       input int dly, input bit poke);
    logic [63:0] a;
    int n;
    bit early, gotDone, expPcEn;
    n = 0; a = sp; early = 0; gotDone = 0;
    ackDelay = dly;
    expPcEn = ld && lk && toPc && !expFault;
    if (!ld) begin
      if (lk) begin a -= 8; push(1, a, regs[1], "R1"); n++; end
      if (gp) begin a -= 8; push(1, a, regs[3], "R1"); n++; end
      if (hi >= lo) for (int i = lo; i <= hi; i++) begin a -= 8; push(1, a, regs[i], "R2"); n++; end
      if (cn) begin a -= 8; push(1, a, MAGIC ^ a, "R3"); n++; end
    end else begin
      if (cn) begin push(0, a, 0, "R4"); a += 8; n++; end
      if (hi >= lo) for (int i = hi; i >= lo; i--) begin push(0, a, 0, "R4"); a += 8; n++; end
      if (gp) begin push(0, a, 0, "R4"); a += 8; n++; end
      if (lk) begin push(0, a, 0, "R4"); a += 8; n++; end
    end
    @(negedge clk);
    isLoad = ld; hiBound = hi; loBound = lo; saveLink = lk; saveGp = gp;
    useCanary = cn; linkToPc = toPc; spIn = sp; start = 1;
    @(negedge clk);
    start = 0;
    if (done) gotDone = 1;
    chk(busy == (n > 0), "R9", "busy after start", busy, n > 0);
    if (poke) begin
      isLoad = ~ld; hiBound = 6'd2; loBound = 6'd0; spIn = 64'hDEAD0; start = 1;
      @(negedge clk);
      start = 0;
    end
    for (int c = 0; c < 2000 && !gotDone; c++) begin
      if (spWrEn && !done) early = 1;
      if (done) gotDone = 1;
      else @(negedge clk);
    end
    chk(gotDone, "R9", "done seen (timeout)", gotDone, 1);
    chk(!early, "R5", "sp written early", early, 0);
    chk(spWrEn, "R5", "spWrEn at done", spWrEn, 1);
    chk(spWrData == (ld ? sp + 64'(8 * n) : sp - 64'(8 * n)), "R5", "final sp",
        spWrData, ld ? sp + 64'(8 * n) : sp - 64'(8 * n));
    chk(canaryFault == expFault, "R7", "canaryFault", canaryFault, expFault);
    chk(pcWrEn == expPcEn, "R6", "pcWrEn", pcWrEn, expPcEn);
    if (expPcEn) chk(pcWrData == expPc, "R6", "pcWrData", pcWrData, expPc);
    chk(!busy, "R9", "busy low at done", busy, 0);
    @(negedge clk);
    chk(!done, "R9", "done one cycle", done, 0);
    chk(expQ.size() == 0, ld ? "R4" : "R1", "accesses left", expQ.size(), 0);
    expQ.delete(); tagQ.delete();
  endtask

  logic [63:0] saved [64];

  initial begin
    #(4 * 200000);
    chk(0, "R9", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) regs[i] = 64'hC0DE_0000_0000_0000 | 64'(i << 8) | 64'(i);
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!busy && !done && !memReq, "R10", "idle outputs", {busy, done, memReq}, 0);
    chk(!spWrEn && !pcWrEn, "R10", "no writes in reset", {spWrEn, pcWrEn}, 0);
    rstN = 1;
    @(negedge clk);
    chk(!busy && !memReq, "R10", "idle after reset", {busy, memReq}, 0);

    // full save then restore into registers
    saved = regs;
    runOp(0, 6'd20, 6'd16, 1, 1, 1, 0, 64'h1000, 0, 0, 0, 0);
    for (int i = 0; i < 64; i++) regs[i] = ~regs[i];
    runOp(1, 6'd20, 6'd16, 1, 1, 1, 0, 64'h1000 - 64'd64, 0, 0, 0, 0);
    chk(regs[1] == saved[1], "R6", "link restored to register", regs[1], saved[1]);
    chk(regs[3] == saved[3], "R4", "gp restored", regs[3], saved[3]);
    for (int i = 16; i <= 20; i++) chk(regs[i] == saved[i], "R4", "range restored", regs[i], saved[i]);
    chk(regs[15] == ~saved[15], "R4", "outside range untouched", regs[15], ~saved[15]);

    // empty range, link + guard, restore into PC
    saved = regs;
    runOp(0, 6'd5, 6'd9, 1, 0, 1, 0, 64'h2000, 0, 0, 2, 0);
    regs[1] = 64'h1234;
    runOp(1, 6'd5, 6'd9, 1, 0, 1, 1, 64'h2000 - 64'd16, 0, saved[1], 1, 0);
    chk(regs[1] == 64'h1234, "R6", "link reg not written in pc mode", regs[1], 64'h1234);

    // single register range
    saved = regs;
    runOp(0, 6'd40, 6'd40, 0, 0, 0, 0, 64'h3000, 0, 0, 1, 0);
    regs[40] = 0;
    runOp(1, 6'd40, 6'd40, 0, 0, 0, 0, 64'h3000 - 64'd8, 0, 0, 3, 0);
    chk(regs[40] == saved[40], "R2", "single register", regs[40], saved[40]);

    // zero-word operation
    runOp(0, 6'd1, 6'd2, 0, 0, 0, 0, 64'h5000, 0, 0, 0, 0);

    // guard mismatch
    saved = regs;
    runOp(0, 6'd12, 6'd10, 1, 0, 1, 0, 64'h4000, 0, 0, 1, 0);
    mem[64'h4000 - 64'd40] = mem[64'h4000 - 64'd40] ^ 64'h1;
    runOp(1, 6'd12, 6'd10, 1, 0, 1, 1, 64'h4000 - 64'd40, 1, saved[1], 0, 0);

    // start ignored while busy, 64-register save
    runOp(0, 6'd63, 6'd0, 1, 1, 1, 0, 64'h8000, 0, 0, 1, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule